// File: doc/BRIEF.md
# Writeback Slot Allocator

This block places completed instructions into a writeback buffer that feeds the commit stage. The buffer holds a fixed number of future cycle rows, and each row has one slot per issue lane. A request that finds its own row full does not bounce: the search carries on into the next row, and then the one after that, until it finds a free slot or runs out of rows. It answers with the row offset (how many ticks before the entry reaches commit) and the slot index inside that row.

A tick marks a processing step. On a tick the head row goes to commit and is then dropped, every later row moves one place toward the head, and the search cursor goes back to row 0, slot 0. Between ticks the cursor stays where the last placement left it. An end-of-execute strobe sends the cursor back to slot 0 of its current row, so that late memory completions search that row from the start. One request is accepted per clock, under a valid/ready handshake.

Top module: `wb_slot_alloc`

## Requirements
- R1: After reset every slot is empty, the head row shows an empty mask and a count of zero, and the cursor sits at row 0, slot 0, so `req_ready` is high.
- R2: A request takes the lowest-numbered free slot at or after the cursor. The linear position is row*LANES + slot.
- R3: When the slots from the cursor to the end of its row are all taken, the search goes on at slot 0 of the next row.
- R4: While `tick` is high, `commit_mask` and `commit_tags` show the head row, and `commit_fire` is high. After that edge, each row holds what the next row held before it, and the last row is empty.
- R5: A granted tag is stored in exactly the slot reported, and no occupied slot is ever written again before its row is retired.
- R6: `req_ready` is low when no free slot lies at or after the cursor within the DEPTH rows. A request made then raises `overflow_err` for that cycle and changes nothing.
- R7: `tick` sets the cursor to row 0, slot 0. `exec_done` without `tick` sets the cursor to slot 0 of its current row.
- R8: A request in the same cycle as `tick` is searched against the buffer after the shift, starting from row 0, slot 0.
- R9: `commit_count` always equals the number of occupied slots in the head row.
- R10: `grant_row` is the row offset from the head (0 means the row retired at the next tick), and `grant_slot` is the lane index. Both are valid only while `grant_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Processing tick: retire head row, shift, reset cursor |
| exec_done | input | 1 | End of execute: cursor back to slot 0 of its row |
| req_valid | input | 1 | Allocation request |
| req_tag | input | TAG_W | Tag to store |
| req_ready | output | 1 | A free slot exists at or after the cursor |
| grant_valid | output | 1 | Request accepted this cycle |
| grant_row | output | RW | Row offset of the placement |
| grant_slot | output | SW | Lane index of the placement |
| overflow_err | output | 1 | Request made with no free slot |
| commit_fire | output | 1 | Head row handed to commit this cycle |
| commit_mask | output | LANES | Occupied slots of the head row |
| commit_tags | output | LANES*TAG_W | Tags of the head row, lane 0 in the low bits |
| commit_count | output | CW | Occupancy count of the head row |

## Verification
The bench builds the block with three lanes and four rows, so the buffer has twelve slots. That size lets a short directed run fill the buffer completely and reach the overflow case. It also lets a search wrap across row boundaries many times during the pseudo-random phase. A first-fit reference model in the bench predicts every grant and every retired head row. Directed steps cover a tick that coincides with a request, and an end-of-execute strobe that moves the cursor back inside a partly filled row.

// File: rtl/wbsa_pkg.sv
package wbsa_pkg;

    // What the search cursor does in a given cycle, before any placement.
    typedef enum logic [1:0] {
        CUR_KEEP      = 2'd0,
        CUR_ROW_START = 2'd1,
        CUR_ZERO      = 2'd2
    } cur_act_e;

    // A tick takes priority over the end-of-execute strobe.
    function automatic cur_act_e cur_action(input logic tick, input logic exec_done);
        if (tick)
            return CUR_ZERO;
        if (exec_done)
            return CUR_ROW_START;
        return CUR_KEEP;
    endfunction

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wbsa_cursor.sv
module wbsa_cursor
    import wbsa_pkg::*;
#(
    parameter int LANES = 4,
    parameter int PW    = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          exec_done,
    input  logic          place,
    input  logic [PW-1:0] place_pos,
    output logic [PW-1:0] start_pos
);

    localparam logic [PW-1:0] LANES_P = PW'(LANES);

    logic [PW-1:0] pos_q;

    always_comb begin
        unique case (cur_action(tick, exec_done))
            CUR_ZERO:      start_pos = '0;
            CUR_ROW_START: start_pos = (pos_q / LANES_P) * LANES_P;
            default:       start_pos = pos_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            pos_q <= '0;
        else if (place)
            pos_q <= place_pos;
        else
            pos_q <= start_pos;
    end

    // R7: with no placement, a tick leaves the cursor at the origin
    a_r7_tick_zero: assert property (@(posedge clk) disable iff (rst)
        (tick && !place) |=> (pos_q == '0));

    // R7: with no placement, exec_done leaves the cursor on a row boundary
    a_r7_exec_row_start: assert property (@(posedge clk) disable iff (rst)
        (!tick && exec_done && !place) |=> ((pos_q % LANES_P) == '0));

endmodule

// File: rtl/wbsa_scan.sv
module wbsa_scan #(
    parameter int N  = 20,
    parameter int PW = 5
) (
    input  logic [N-1:0]  occ,
    input  logic [PW-1:0] start,
    output logic          found,
    output logic [PW-1:0] pos
);

    // Walk downward so that the last hit is the lowest free position.
    always_comb begin
        found = 1'b0;
        pos   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!occ[i] && (PW'(i) >= start)) begin
                found = 1'b1;
                pos   = PW'(i);
            end
        end
    end

endmodule

// File: rtl/wbsa_rows.sv
module wbsa_rows #(
    parameter int LANES = 4,
    parameter int DEPTH = 5,
    parameter int TAG_W = 8,
    parameter int PW    = 5,
    parameter int CW    = 3
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   shift,
    input  logic                   wr_en,
    input  logic [PW-1:0]          wr_pos,
    input  logic [TAG_W-1:0]       wr_tag,
    output logic [LANES*DEPTH-1:0] view_occ,
    output logic [LANES-1:0]       head_occ,
    output logic [LANES*TAG_W-1:0] head_tags,
    output logic [CW-1:0]          head_cnt
);

    logic [LANES-1:0] occ_q [DEPTH];
    logic [TAG_W-1:0] tag_q [DEPTH][LANES];
    logic [CW-1:0]    cnt_q [DEPTH];

    logic [LANES-1:0] occ_v [DEPTH];
    logic [TAG_W-1:0] tag_v [DEPTH][LANES];
    logic [CW-1:0]    cnt_v [DEPTH];
    logic [LANES-1:0] hit   [DEPTH];

    // Row contents as seen this cycle: shifted toward the head on a tick.
    for (genvar r = 0; r < DEPTH; r++) begin : g_row
        if (r == DEPTH - 1) begin : g_top
            assign occ_v[r] = shift ? '0 : occ_q[r];
            assign cnt_v[r] = shift ? '0 : cnt_q[r];
        end else begin : g_mid
            assign occ_v[r] = shift ? occ_q[r+1] : occ_q[r];
            assign cnt_v[r] = shift ? cnt_q[r+1] : cnt_q[r];
        end
        assign view_occ[r*LANES +: LANES] = occ_v[r];

        for (genvar s = 0; s < LANES; s++) begin : g_slot
            if (r == DEPTH - 1) begin : g_ttop
                assign tag_v[r][s] = shift ? '0 : tag_q[r][s];
            end else begin : g_tmid
                assign tag_v[r][s] = shift ? tag_q[r+1][s] : tag_q[r][s];
            end
            assign hit[r][s] = wr_en && (wr_pos == PW'(r*LANES + s));
        end
    end

    for (genvar s = 0; s < LANES; s++) begin : g_head
        assign head_tags[s*TAG_W +: TAG_W] = tag_q[0][s];
    end
    assign head_occ = occ_q[0];
    assign head_cnt = cnt_q[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < DEPTH; r++) begin
                occ_q[r] <= '0;
                cnt_q[r] <= '0;
                for (int s = 0; s < LANES; s++)
                    tag_q[r][s] <= '0;
            end
        end else begin
            for (int r = 0; r < DEPTH; r++) begin
                occ_q[r] <= occ_v[r] | hit[r];
                cnt_q[r] <= cnt_v[r] + CW'(|hit[r]);
                for (int s = 0; s < LANES; s++)
                    tag_q[r][s] <= hit[r][s] ? wr_tag : tag_v[r][s];
            end
        end
    end

    // R5: a placement never lands on a slot that is already taken
    a_r5_single_write: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> !view_occ[wr_pos]);

    // R4: on a tick the head takes over the count of the row behind it
    if (DEPTH > 1) begin : g_shift_chk
        a_r4_shift_moves: assert property (@(posedge clk) disable iff (rst)
            (shift && !wr_en) |=> (head_cnt == $past(cnt_q[1])));
    end

endmodule

// File: rtl/wb_slot_alloc.sv
module wb_slot_alloc
    import wbsa_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 5,
    parameter int TAG_W = 8,
    localparam int N    = LANES * DEPTH,
    localparam int PW   = $clog2(N + 1),
    localparam int RW   = width_of(DEPTH),
    localparam int SW   = width_of(LANES),
    localparam int CW   = $clog2(LANES + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   tick,
    input  logic                   exec_done,
    input  logic                   req_valid,
    input  logic [TAG_W-1:0]       req_tag,
    output logic                   req_ready,
    output logic                   grant_valid,
    output logic [RW-1:0]          grant_row,
    output logic [SW-1:0]          grant_slot,
    output logic                   overflow_err,
    output logic                   commit_fire,
    output logic [LANES-1:0]       commit_mask,
    output logic [LANES*TAG_W-1:0] commit_tags,
    output logic [CW-1:0]          commit_count
);

    localparam logic [PW-1:0] LANES_P = PW'(LANES);

    logic [N-1:0]  view_occ;
    logic [PW-1:0] start_pos;
    logic [PW-1:0] free_pos;
    logic          free_found;
    logic          place;

    wbsa_cursor #(.LANES(LANES), .PW(PW)) u_cursor (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .exec_done (exec_done),
        .place     (place),
        .place_pos (free_pos),
        .start_pos (start_pos)
    );

    wbsa_scan #(.N(N), .PW(PW)) u_scan (
        .occ   (view_occ),
        .start (start_pos),
        .found (free_found),
        .pos   (free_pos)
    );

    wbsa_rows #(.LANES(LANES), .DEPTH(DEPTH), .TAG_W(TAG_W), .PW(PW), .CW(CW)) u_rows (
        .clk       (clk),
        .rst       (rst),
        .shift     (tick),
        .wr_en     (place),
        .wr_pos    (free_pos),
        .wr_tag    (req_tag),
        .view_occ  (view_occ),
        .head_occ  (commit_mask),
        .head_tags (commit_tags),
        .head_cnt  (commit_count)
    );

    assign place        = req_valid && free_found;
    assign req_ready    = free_found;
    assign grant_valid  = place;
    assign grant_row    = RW'(free_pos / LANES_P);
    assign grant_slot   = SW'(free_pos % LANES_P);
    assign overflow_err = req_valid && !free_found;
    assign commit_fire  = tick;

    // R6: after an overflow, room appears again only through a tick
    a_r6_full_persists: assert property (@(posedge clk) disable iff (rst)
        overflow_err |=> (tick || !req_ready));

    // R9: head count and head mask are kept by separate registers
    a_r9_count_matches: assert property (@(posedge clk) disable iff (rst)
        commit_count == CW'($countones(commit_mask)));

endmodule

// File: tb/test_wb_slot_alloc.sv
module test_wb_slot_alloc;

    localparam int W  = 3;
    localparam int D  = 4;
    localparam int TW = 8;
    localparam int N  = W * D;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            tick = 1'b0;
    logic            exec_done = 1'b0;
    logic            req_valid = 1'b0;
    logic [TW-1:0]   req_tag = '0;
    logic            req_ready;
    logic            grant_valid;
    logic [1:0]      grant_row;
    logic [1:0]      grant_slot;
    logic            overflow_err;
    logic            commit_fire;
    logic [W-1:0]    commit_mask;
    logic [W*TW-1:0] commit_tags;
    logic [1:0]      commit_count;

    wb_slot_alloc #(.LANES(W), .DEPTH(D), .TAG_W(TW)) i_wb_slot_alloc (
        .clk, .rst, .tick, .exec_done, .req_valid, .req_tag,
        .req_ready, .grant_valid, .grant_row, .grant_slot, .overflow_err,
        .commit_fire, .commit_mask, .commit_tags, .commit_count
    );

    always #4 clk = ~clk;

    typedef struct {
        string   lbl;
        bit      rdy;
        bit      gv;
        int      row;
        int      slot;
        bit      err;
        bit      fire;
        bit [W-1:0] mask;
        int      cnt;
        bit [TW-1:0] tags [W];
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int errors = 0;
    bit done   = 0;

    // Reference first-fit model
    bit         m_occ [D][W];
    bit [TW-1:0] m_tag [D][W];
    int         m_ptr;

    task automatic model_reset();
        for (int r = 0; r < D; r++)
            for (int s = 0; s < W; s++) begin
                m_occ[r][s] = 0;
                m_tag[r][s] = '0;
            end
        m_ptr = 0;
    endtask

    task automatic chk(input string req, input string lbl, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s [%s] actual %0d expected %0d", req, lbl, act, exp);
        end
    endtask

    task automatic step(input bit v, input bit [TW-1:0] tg, input bit tk, input bit ex,
                        input string lbl);
        exp_t e;
        int p;
        @(negedge clk);
        req_valid = v; req_tag = tg; tick = tk; exec_done = ex;
        e.lbl  = lbl;
        e.fire = tk;
        e.cnt  = 0;
        for (int s = 0; s < W; s++) begin
            e.mask[s] = m_occ[0][s];
            e.tags[s] = m_tag[0][s];
            if (m_occ[0][s]) e.cnt++;
        end
        if (tk) begin
            for (int r = 0; r < D; r++)
                for (int s = 0; s < W; s++) begin
                    m_occ[r][s] = (r < D-1) ? m_occ[r+1][s] : 1'b0;
                    m_tag[r][s] = (r < D-1) ? m_tag[r+1][s] : '0;
                end
            m_ptr = 0;
        end else if (ex) begin
            m_ptr = (m_ptr / W) * W;
        end
        p = -1;
        for (int i = m_ptr; i < N; i++)
            if (p < 0 && !m_occ[i / W][i % W]) p = i;
        e.rdy  = (p >= 0);
        e.gv   = v && (p >= 0);
        e.err  = v && (p < 0);
        e.row  = (p >= 0) ? p / W : 0;
        e.slot = (p >= 0) ? p % W : 0;
        if (e.gv) begin
            m_occ[p / W][p % W] = 1'b1;
            m_tag[p / W][p % W] = tg;
            m_ptr = p;
        end
        q.push_back(e);
    endtask

    // Monitor: compares each cycle's outputs against the queued prediction
    initial begin
        forever begin
            @(negedge clk);
            #3;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                chk("R6 ready", e.lbl, int'(req_ready), int'(e.rdy));
                chk("R2 grant_valid", e.lbl, int'(grant_valid), int'(e.gv));
                chk("R6 overflow_err", e.lbl, int'(overflow_err), int'(e.err));
                if (e.gv) begin
                    chk("R3 R10 grant_row", e.lbl, int'(grant_row), e.row);
                    chk("R2 R10 grant_slot", e.lbl, int'(grant_slot), e.slot);
                end
                chk("R4 commit_fire", e.lbl, int'(commit_fire), int'(e.fire));
                chk("R4 commit_mask", e.lbl, int'(commit_mask), int'(e.mask));
                chk("R9 commit_count", e.lbl, int'(commit_count), e.cnt);
                for (int s = 0; s < W; s++)
                    if (e.mask[s])
                        chk("R5 commit_tag", e.lbl, int'(commit_tags[s*TW +: TW]), int'(e.tags[s]));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit [15:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        step(0, 8'h00, 0, 0, "R1 after reset");
        // first-fit inside row 0, then wrap into row 1
        step(1, 8'h01, 0, 0, "R2 slot0");
        step(1, 8'h02, 0, 0, "R2 slot1");
        step(1, 8'h03, 0, 0, "R2 slot2");
        step(1, 8'h04, 0, 0, "R3 wrap to row1");
        step(1, 8'h05, 0, 0, "R3 row1 slot1");
        // cursor back to row start, search still skips taken slots
        step(1, 8'h06, 0, 1, "R7 exec_done");
        // tick with a request: retire row 0, search shifted buffer from origin
        step(1, 8'h07, 1, 0, "R8 tick plus request");
        for (int k = 0; k < 8; k++)
            step(1, 8'h10 + 8'(k), 0, 0, "R3 fill");
        step(1, 8'hEE, 0, 0, "R6 overflow");
        step(0, 8'h00, 0, 1, "R6 still full");
        step(0, 8'h00, 1, 0, "R4 retire head");
        step(0, 8'h00, 1, 0, "R7 R4 retire again");

        lfsr = 16'hACE1;
        for (int k = 0; k < 600; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0] | lfsr[1], lfsr[15:8], (lfsr[4:2] == 3'd0), (lfsr[7:5] == 3'd1),
                 "R5 random");
        end

        @(negedge clk);
        req_valid = 0; tick = 0; exec_done = 0;
        #6;
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule